// File: doc/BRIEF.md
# Device-Selected DMA Context Loader

This block lets a storage device pick which queued command's buffer the host DMA engine serves next. While it builds each command, software writes a scatter/gather table pointer into one of 32 tag-indexed slots and marks the slot valid. The device later sends a setup request that names a tag and a transfer direction. The block looks up the slot in hardware and loads the pointer, tag and direction into the DMA engine's context registers. It then pulses a start strobe. No interrupt and no software step sit between the request and the start.

A request is accepted on a ready/valid handshake. From acceptance, the load takes one cycle for the table read and a second cycle for the start pulse. After it issues a start, the block treats the engine as occupied and holds off further requests until the engine reports done. A request whose slot is not valid is never forwarded. The block instead raises a one-cycle error pulse that carries the tag. Software clears a slot when its command retires.

Top module: `fpdma_ctx_sel`

## Requirements
- R1: Out of reset, every slot is invalid, `req_ready` is 1, `dma_start` and `err_valid` are 0, and `ctx_ptr`, `ctx_tag` and `ctx_dir` are 0.
- R2: When a request is accepted (`req_valid` and `req_ready` both 1 at a rising edge) and its slot is valid, `dma_start` is 1 for exactly one cycle, starting after the second rising edge counted from acceptance. In that same cycle `ctx_ptr` holds the slot's pointer and `ctx_tag` holds the request tag.
- R3: In the start cycle, `ctx_dir` equals the `req_dir` bit of the accepted request (1 = device to host, 0 = host to device).
- R4: When an accepted request names an invalid slot, no start is issued. `err_valid` is 1 for one cycle with `err_tag` equal to the request tag, at the same point in time a start would have occurred. `ctx_ptr`, `ctx_tag` and `ctx_dir` keep their previous values.
- R5: `req_ready` is 0 from the cycle after acceptance until the rising edge at which `dma_done` is sampled 1 after a start. A request held valid during that time is neither accepted nor acted on.
- R6: After an error outcome, `req_ready` is 1 again in the same cycle that `err_valid` is 1.
- R7: A slot write and a lookup of the same tag at the same rising edge use the slot's old contents.
- R8: A pulse on `inv_en` makes slot `inv_tag` invalid. If a write and an invalidation name the same slot at the same edge, the invalidation wins.
- R9: `dma_done` has no effect while no start is outstanding.
- R10: Each of the 32 tags selects its own slot, and writing one slot leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software slot write strobe (sets the slot valid) |
| wr_tag | input | 5 | Slot index for the write |
| wr_ptr | input | 32 | Scatter/gather table pointer to store |
| inv_en | input | 1 | Software slot invalidate strobe |
| inv_tag | input | 5 | Slot index for the invalidation |
| req_valid | input | 1 | Device setup request present |
| req_ready | output | 1 | Block can accept a setup request |
| req_tag | input | 5 | Tag named by the setup request |
| req_dir | input | 1 | Direction: 1 device to host, 0 host to device |
| ctx_ptr | output | 32 | Loaded pointer for the DMA engine |
| ctx_tag | output | 5 | Loaded tag |
| ctx_dir | output | 1 | Loaded direction |
| dma_start | output | 1 | One-cycle start strobe to the DMA engine |
| dma_done | input | 1 | Engine finished the started transfer |
| err_valid | output | 1 | One-cycle pulse: request named an invalid slot |
| err_tag | output | 5 | Tag of the rejected request |

## Verification
A corrupted slot valid bit shows up two edges after the next request for that tag: a start appears where an error pulse was due, or the reverse. A corrupted pointer appears on `ctx_ptr` during the start cycle of that same request. A stuck or missed busy flag is visible within one cycle as a wrong `req_ready`. The consequences are a second start while the engine is occupied, or a block that stays stalled after `dma_done`. Same-edge write/lookup and write/invalidate cases are driven on purpose, because a priority error there shows only at those exact edges.

// File: rtl/fpdma_ctx_pkg.sv
// Shared types for the device-selected DMA context loader.
package fpdma_ctx_pkg;

    // Outcome of a looked-up request, one cycle after acceptance.
    typedef enum logic [1:0] {
        OUTC_NONE  = 2'd0,
        OUTC_START = 2'd1,
        OUTC_ERROR = 2'd2
    } outcome_e;

endpackage

// File: rtl/fpdma_ctx_table.sv
// Tag-indexed slot table: one pointer and one valid bit per tag.
// Assumes NUM_TAGS == 2**TAG_W. Invalidation beats a write to the same
// slot. The read port is combinational on the registered contents, so a
// lookup at the edge of a write sees the old contents.
module fpdma_ctx_table #(
    parameter int unsigned TAG_W = 5,
    parameter int unsigned PTR_W = 32,
    localparam int unsigned NUM_TAGS = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             inv_en,
    input  logic [TAG_W-1:0] inv_tag,
    input  logic [TAG_W-1:0] rd_tag,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             rd_valid
);

    logic [PTR_W-1:0] slot_ptr [NUM_TAGS];
    logic [NUM_TAGS-1:0] slot_vld;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        // Per-slot update: reset, then invalidate, then write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[g] <= 1'b0;
                slot_ptr[g] <= '0;
            end else if (inv_en && (inv_tag == TAG_W'(g))) begin
                slot_vld[g] <= 1'b0;
            end else if (wr_en && (wr_tag == TAG_W'(g))) begin
                slot_vld[g] <= 1'b1;
                slot_ptr[g] <= wr_ptr;
            end
        end
    end

    // Read port on the registered contents.
    always_comb begin
        rd_ptr   = slot_ptr[rd_tag];
        rd_valid = slot_vld[rd_tag];
    end

endmodule

// File: rtl/fpdma_req_ctrl.sv
// Request handshake, lookup stage and engine-occupied tracking.
// Assumes dma_done is a pulse sent only after a start; a done that
// arrives with no start outstanding is ignored.
module fpdma_req_ctrl
    import fpdma_ctx_pkg::*;
#(
    parameter int unsigned TAG_W = 5,
    parameter int unsigned PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_dir,
    input  logic             dma_done,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic             rd_valid,
    output outcome_e         st_outc,
    output logic [PTR_W-1:0] st_ptr,
    output logic [TAG_W-1:0] st_tag,
    output logic             st_dir
);

    logic st_vld;
    logic st_hit;
    logic eng_busy;
    logic accept;

    assign req_ready = !st_vld && !eng_busy;
    assign accept    = req_valid && req_ready;

    // Lookup stage: capture the slot contents at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld <= 1'b0;
            st_hit <= 1'b0;
            st_ptr <= '0;
            st_tag <= '0;
            st_dir <= 1'b0;
        end else begin
            st_vld <= accept;
            if (accept) begin
                st_hit <= rd_valid;
                st_ptr <= rd_ptr;
                st_tag <= req_tag;
                st_dir <= req_dir;
            end
        end
    end

    // Engine occupancy: set with a start, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_busy <= 1'b0;
        end else if (st_vld && st_hit) begin
            eng_busy <= 1'b1;
        end else if (dma_done) begin
            eng_busy <= 1'b0;
        end
    end

    // Outcome decode for the output stage.
    always_comb begin
        if (!st_vld)     st_outc = OUTC_NONE;
        else if (st_hit) st_outc = OUTC_START;
        else             st_outc = OUTC_ERROR;
    end

endmodule

// File: rtl/fpdma_ctx_out.sv
// Context output registers, start strobe and error report.
// The context holds its last loaded value until the next start.
module fpdma_ctx_out
    import fpdma_ctx_pkg::*;
#(
    parameter int unsigned TAG_W = 5,
    parameter int unsigned PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  outcome_e         st_outc,
    input  logic [PTR_W-1:0] st_ptr,
    input  logic [TAG_W-1:0] st_tag,
    input  logic             st_dir,
    output logic [PTR_W-1:0] ctx_ptr,
    output logic [TAG_W-1:0] ctx_tag,
    output logic             ctx_dir,
    output logic             dma_start,
    output logic             err_valid,
    output logic [TAG_W-1:0] err_tag
);

    // Load the engine context on a start outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_ptr <= '0;
            ctx_tag <= '0;
            ctx_dir <= 1'b0;
        end else if (st_outc == OUTC_START) begin
            ctx_ptr <= st_ptr;
            ctx_tag <= st_tag;
            ctx_dir <= st_dir;
        end
    end

    // One-cycle strobes for start and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_start <= 1'b0;
            err_valid <= 1'b0;
            err_tag   <= '0;
        end else begin
            dma_start <= (st_outc == OUTC_START);
            err_valid <= (st_outc == OUTC_ERROR);
            if (st_outc == OUTC_ERROR) err_tag <= st_tag;
        end
    end

endmodule

// File: rtl/fpdma_ctx_sel.sv
// Top: device-selected DMA context loader. Software fills the slots, a
// device request names a tag, and the hardware loads the context and
// starts the engine two edges after acceptance.
module fpdma_ctx_sel
    import fpdma_ctx_pkg::*;
#(
    parameter int unsigned TAG_W = 5,
    parameter int unsigned PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             inv_en,
    input  logic [TAG_W-1:0] inv_tag,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_dir,
    output logic [PTR_W-1:0] ctx_ptr,
    output logic [TAG_W-1:0] ctx_tag,
    output logic             ctx_dir,
    output logic             dma_start,
    input  logic             dma_done,
    output logic             err_valid,
    output logic [TAG_W-1:0] err_tag
);

    logic [PTR_W-1:0] rd_ptr;
    logic             rd_valid;
    outcome_e         st_outc;
    logic [PTR_W-1:0] st_ptr;
    logic [TAG_W-1:0] st_tag;
    logic             st_dir;

    fpdma_ctx_table #(.TAG_W(TAG_W), .PTR_W(PTR_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_ptr(wr_ptr),
        .inv_en(inv_en), .inv_tag(inv_tag),
        .rd_tag(req_tag), .rd_ptr(rd_ptr), .rd_valid(rd_valid)
    );

    fpdma_req_ctrl #(.TAG_W(TAG_W), .PTR_W(PTR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_tag(req_tag), .req_dir(req_dir), .dma_done(dma_done),
        .rd_ptr(rd_ptr), .rd_valid(rd_valid),
        .st_outc(st_outc), .st_ptr(st_ptr), .st_tag(st_tag), .st_dir(st_dir)
    );

    fpdma_ctx_out #(.TAG_W(TAG_W), .PTR_W(PTR_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .st_outc(st_outc), .st_ptr(st_ptr), .st_tag(st_tag), .st_dir(st_dir),
        .ctx_ptr(ctx_ptr), .ctx_tag(ctx_tag), .ctx_dir(ctx_dir),
        .dma_start(dma_start), .err_valid(err_valid), .err_tag(err_tag)
    );

endmodule

// File: rtl/fpdma_ctx_sel_chk.sv
// Port-level protocol checker for fpdma_ctx_sel, bound to every instance.
module fpdma_ctx_sel_chk #(
    parameter int unsigned TAG_W = 5,
    parameter int unsigned PTR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [TAG_W-1:0] req_tag,
    input logic             req_dir,
    input logic [PTR_W-1:0] ctx_ptr,
    input logic [TAG_W-1:0] ctx_tag,
    input logic             ctx_dir,
    input logic             dma_start,
    input logic             err_valid,
    input logic [TAG_W-1:0] err_tag
);

    // R2: every start follows an acceptance two edges earlier
    p_start_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> $past(req_valid && req_ready, 2));

    // R2: start is a single-cycle pulse
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);

    // R2: loaded tag is the accepted tag
    p_ctx_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> ctx_tag == $past(req_tag, 2));

    // R3: loaded direction is the accepted direction
    p_ctx_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> ctx_dir == $past(req_dir, 2));

    // R4: error and start never together; error keeps context
    p_err_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_start && err_valid));
    p_err_ctx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $stable(ctx_ptr) && $stable(ctx_tag));
    p_err_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> err_tag == $past(req_tag, 2));

    // R5: not ready while a start is being issued
    p_busy_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> !req_ready);

    // R6: ready again alongside an error pulse
    p_err_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> req_ready);

endmodule

bind fpdma_ctx_sel fpdma_ctx_sel_chk #(.TAG_W(TAG_W), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .req_dir(req_dir), .ctx_ptr(ctx_ptr), .ctx_tag(ctx_tag),
    .ctx_dir(ctx_dir), .dma_start(dma_start), .err_valid(err_valid),
    .err_tag(err_tag)
);

// File: tb/tb_fpdma_ctx_sel.sv
module tb_fpdma_ctx_sel;

    localparam int TAG_W = 5;
    localparam int PTR_W = 32;
    localparam int NT = 1 << TAG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, inv_en = 0, req_valid = 0, req_dir = 0, dma_done = 0;
    logic [TAG_W-1:0] wr_tag = 0, inv_tag = 0, req_tag = 0;
    logic [PTR_W-1:0] wr_ptr = 0;
    logic req_ready, ctx_dir, dma_start, err_valid;
    logic [PTR_W-1:0] ctx_ptr;
    logic [TAG_W-1:0] ctx_tag, err_tag;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;
    logic [PTR_W-1:0] m_ptr [NT];
    bit m_val [NT];

    always #2 clk = ~clk;

    fpdma_ctx_sel #(.TAG_W(TAG_W), .PTR_W(PTR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tag(wr_tag), .wr_ptr(wr_ptr),
        .inv_en(inv_en), .inv_tag(inv_tag), .req_valid(req_valid),
        .req_ready(req_ready), .req_tag(req_tag), .req_dir(req_dir),
        .ctx_ptr(ctx_ptr), .ctx_tag(ctx_tag), .ctx_dir(ctx_dir),
        .dma_start(dma_start), .dma_done(dma_done), .err_valid(err_valid),
        .err_tag(err_tag)
    );

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", r, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic sw_write(input int t, input logic [PTR_W-1:0] p);
        wr_en = 1; wr_tag = TAG_W'(t); wr_ptr = p;
        tick();
        wr_en = 0;
        m_ptr[t] = p; m_val[t] = 1;
    endtask

    task automatic sw_inv(input int t);
        inv_en = 1; inv_tag = TAG_W'(t);
        tick();
        inv_en = 0;
        m_val[t] = 0;
    endtask

    // Issue a request and check its outcome; expected values taken at acceptance.
    task automatic do_req(input int t, input bit d);
        bit hit;
        logic [PTR_W-1:0] eptr, pptr;
        logic [TAG_W-1:0] ptag;
        req_valid = 1; req_tag = TAG_W'(t); req_dir = d;
        while (!req_ready) tick();
        hit = m_val[t]; eptr = m_ptr[t]; pptr = ctx_ptr; ptag = ctx_tag;
        tick();
        req_valid = 0;
        chk(!dma_start && !err_valid, "R2 no early outcome", {dma_start, err_valid}, 0);
        chk(!req_ready, "R5 stage busy", req_ready, 0);
        tick();
        if (hit) begin
            chk(dma_start == 1, "R2 start", dma_start, 1);
            chk(ctx_ptr == eptr, "R2 ptr", ctx_ptr, eptr);
            chk(ctx_tag == TAG_W'(t), "R2 tag", ctx_tag, t);
            chk(ctx_dir == d, "R3 dir", ctx_dir, d);
            chk(!req_ready, "R5 busy", req_ready, 0);
            tick();
            chk(!dma_start, "R2 pulse width", dma_start, 0);
            dma_done = 1;
            tick();
            dma_done = 0;
            chk(req_ready, "R5 ready after done", req_ready, 1);
        end else begin
            chk(err_valid && err_tag == TAG_W'(t), "R4 error", {err_valid, err_tag}, {1'b1, TAG_W'(t)});
            chk(!dma_start, "R4 no start", dma_start, 0);
            chk(ctx_ptr == pptr && ctx_tag == ptag, "R4 ctx kept", ctx_ptr, pptr);
            chk(req_ready, "R6 ready", req_ready, 1);
            tick();
            chk(!err_valid, "R4 pulse width", err_valid, 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NT; i++) begin m_ptr[i] = 0; m_val[i] = 0; end
        repeat (3) tick();
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !dma_start && !err_valid, "R1 handshake", {req_ready, dma_start, err_valid}, 3'b100);
        chk(ctx_ptr == 0 && ctx_tag == 0 && ctx_dir == 0, "R1 context", ctx_ptr, 0);
        do_req(7, 1);                 // R1 all slots invalid after reset

        // R10 fill every slot, then look each up
        for (int i = 0; i < NT; i++) sw_write(i, 32'hA000_0000 + 32'(i * 16'h1111));
        for (int i = 0; i < NT; i++) do_req(i, i[0]);

        // R7 same-edge write and lookup: old (invalid) contents used
        sw_inv(9);
        wr_en = 1; wr_tag = 9; wr_ptr = 32'hDEAD_BEEF;
        req_valid = 1; req_tag = 9; req_dir = 0;
        tick();
        wr_en = 0; req_valid = 0;
        tick();
        chk(err_valid && !dma_start, "R7 old invalid", {err_valid, dma_start}, 2'b10);
        m_ptr[9] = 32'hDEAD_BEEF; m_val[9] = 1;
        do_req(9, 1);                 // R7 new contents visible afterwards
        // R7 same-edge overwrite of a valid slot: old pointer used
        wr_en = 1; wr_tag = 9; wr_ptr = 32'h1234_5678;
        req_valid = 1; req_tag = 9; req_dir = 1;
        tick();
        wr_en = 0; req_valid = 0;
        tick();
        chk(dma_start && ctx_ptr == 32'hDEAD_BEEF, "R7 old ptr", ctx_ptr, 32'hDEAD_BEEF);
        dma_done = 1; tick(); dma_done = 0;
        m_ptr[9] = 32'h1234_5678;

        // R8 write and invalidate on the same slot and edge: invalid wins
        wr_en = 1; wr_tag = 4; wr_ptr = 32'h5555_0000;
        inv_en = 1; inv_tag = 4;
        tick();
        wr_en = 0; inv_en = 0;
        m_val[4] = 0;
        do_req(4, 0);

        // R5 request held while engine busy is not acted on
        req_valid = 1; req_tag = 2; req_dir = 1;
        tick(); req_valid = 1;
        tick();
        chk(dma_start, "R5 first start", dma_start, 1);
        req_tag = 3;
        for (int k = 0; k < 5; k++) begin
            tick();
            chk(!dma_start && !err_valid && !req_ready, "R5 held off", {dma_start, err_valid, req_ready}, 0);
        end
        req_valid = 0;
        dma_done = 1; tick(); dma_done = 0;
        chk(req_ready, "R5 released", req_ready, 1);

        // R9 stray done while idle changes nothing
        dma_done = 1; tick(); dma_done = 0;
        chk(req_ready && !dma_start, "R9 idle done", req_ready, 1);
        do_req(5, 0);
        // R9 done arriving in the lookup cycle does not pre-clear busy
        req_valid = 1; req_tag = 6; req_dir = 0;
        tick(); req_valid = 0; dma_done = 1;
        tick(); dma_done = 0;
        chk(dma_start && !req_ready, "R9 busy kept", req_ready, 0);
        dma_done = 1; tick(); dma_done = 0;

        // Random mix of writes, invalidations and requests
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 9);
            int t = $urandom_range(0, NT - 1);
            if (op < 3) sw_write(t, $urandom);
            else if (op < 5) sw_inv(t);
            else do_req(t, 1'($urandom_range(0, 1)));
        end
        finish_run();
    end

endmodule